// File: doc/BRIEF.md
# Latch-up power guard

This block guards a supply rail against a latch-up current surge. A free-running sample timer fires once per second. On each firing the block requests one conversion from an external current-sense converter over a start/done/data handshake. Each returned value is compared against a threshold that is captured when the conversion starts. A run of consecutive readings strictly above the threshold, three by default, trips the guard. The guard then drops the power enable for 10 ms and raises it again by itself. After that it ignores a programmable number of sample periods, so that inrush current cannot count toward a new trip.

Every trip produces a one-cycle pulse. The trip is also recorded in a saturating event counter and in a sticky flag, and one clear input resets both. A status byte shows the live state of the guard. The sample period and the off time are derived from the clock frequency. A fast-simulation setting shortens them to 64 and 16 clock cycles.

Top module: `latchup_guard`

## Requirements
- R1: While reset is held and right after it: power_en is 1, trip_pulse and adc_start are 0, trip_count is 0, and status is 8'h02. The status bits are: bit 0 sticky trip flag, bit 1 power on, bit 2 blanking active, bit 3 conversion pending, bits 7:4 consecutive-exceed streak.
- R2: Each sample period (64 cycles with the fast setting) issues at most one adc_start. adc_start is a single-cycle pulse and is never issued while a conversion is pending.
- R3: A reading counts as an exceed only when it is strictly greater than the threshold. Any reading equal to or below the threshold resets the streak to zero.
- R4: When TRIP_COUNT (default 3) consecutive readings exceed the threshold, trip_pulse is high for exactly one cycle. power_en is 0 in that same cycle.
- R5: power_en stays low for exactly the off time (16 cycles with the fast setting, otherwise 10 ms of clock) and then returns to 1 without any outside action.
- R6: No conversion is started while power is off. After power returns, blank_ticks sample periods pass without any conversion, and monitoring then resumes. With blank_ticks = 0, monitoring resumes at once.
- R7: The threshold in force for a reading is the one present when that reading's conversion was started. A change made during a pending conversion applies only from the next conversion.
- R8: Each trip raises the sticky flag and increments trip_count, which saturates at its maximum. A clr_trip pulse sets trip_count to 0 and the sticky flag to 0. If a trip happens in the same cycle as the clear, the count becomes 1 and the flag 1.
- R9: An adc_done that arrives while no conversion is pending has no effect on the streak or on a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thresh | input | ADC_W | Over-current threshold, captured at conversion start |
| blank_ticks | input | 4 | Sample periods ignored after power returns |
| clr_trip | input | 1 | Clears the trip counter and the sticky flag |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | ADC_W | Converter result |
| adc_start | output | 1 | Conversion request pulse |
| power_en | output | 1 | Supply enable |
| trip_pulse | output | 1 | One-cycle pulse on each trip |
| trip_count | output | CNT_W | Saturating trip event counter |
| status | output | 8 | Sticky flag, power, blanking, pending, streak |

## Verification
The trip path is driven with several reading patterns. One is an unbroken run of high readings, which must trip on exactly the third conversion. Another is a run broken by a single low reading, which must delay the trip to the sixth. A third uses readings exactly equal to the threshold, which must never trip; this separates a strict compare from a greater-or-equal compare. Further cases check the following. A threshold change made while a conversion is pending must shift the trip by one conversion. Unsolicited done strobes carrying large values must leave the streak at zero. With blank_ticks set to 2, the delay from power return to the next conversion must be more than two sample periods, against less than one period with blank_ticks set to 0. A run of four trips on a two-bit counter must saturate it at 3.

// File: rtl/lg_pkg.sv
package lg_pkg;

    localparam int FAST_SAMPLE_CYC = 64;
    localparam int FAST_OFF_CYC    = 16;
    localparam int OFF_DIVISOR     = 100;   // 10 ms = clock rate / 100
    localparam int STRK_W          = 4;

    typedef enum logic [1:0] {
        PW_RUN   = 2'd0,
        PW_OFF   = 2'd1,
        PW_BLANK = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic [STRK_W-1:0] streak;
        logic              pending;
        logic              blanking;
        logic              power_on;
        logic              sticky;
    } guard_status_t;

    function automatic int sample_cycles(int clk_hz, bit fast);
        return fast ? FAST_SAMPLE_CYC : clk_hz;
    endfunction

    function automatic int off_cycles(int clk_hz, bit fast);
        return fast ? FAST_OFF_CYC : clk_hz / OFF_DIVISOR;
    endfunction

endpackage

// File: rtl/lg_tick.sv
module lg_tick #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = $clog2(PERIOD + 1);
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/lg_sampler.sv
module lg_sampler
    import lg_pkg::*;
#(
    parameter int ADC_W      = 12,
    parameter int TRIP_COUNT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              mon_en,
    input  logic [ADC_W-1:0]  thresh,
    input  logic              adc_done,
    input  logic [ADC_W-1:0]  adc_data,
    output logic              adc_start,
    output logic              trip_req,
    output logic [STRK_W-1:0] streak,
    output logic              pending
);
    localparam logic [STRK_W-1:0] LAST_STRK = STRK_W'(TRIP_COUNT - 1);

    logic [ADC_W-1:0] thr_q;
    logic             over;

    assign over = adc_data > thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_start <= 1'b0;
            trip_req  <= 1'b0;
            streak    <= '0;
            pending   <= 1'b0;
            thr_q     <= '0;
        end else begin
            adc_start <= 1'b0;
            trip_req  <= 1'b0;
            if (!mon_en) begin
                pending <= 1'b0;
                streak  <= '0;
            end else if (pending) begin
                if (adc_done) begin
                    pending <= 1'b0;
                    if (!over) begin
                        streak <= '0;
                    end else if (streak == LAST_STRK) begin
                        streak   <= '0;
                        trip_req <= 1'b1;
                    end else begin
                        streak <= streak + 1'b1;
                    end
                end
            end else if (tick && !trip_req) begin
                adc_start <= 1'b1;
                pending   <= 1'b1;
                thr_q     <= thresh;
            end
        end
    end

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (pending && !adc_start) |=> !adc_start);
    p_below_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (mon_en && pending && adc_done && (adc_data <= thr_q)) |=> (streak == '0));
    p_streak_bound_r4: assert property (@(posedge clk) disable iff (rst)
        streak <= LAST_STRK);
    p_spurious_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (mon_en && !pending && adc_done) |=> $stable(streak));

endmodule

// File: rtl/lg_power_seq.sv
module lg_power_seq
    import lg_pkg::*;
#(
    parameter int OFF_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       trip_req,
    input  logic [3:0] blank_ticks,
    output logic       power_en,
    output logic       trip_pulse,
    output logic       mon_en,
    output logic       blanking
);
    localparam int OFF_W = $clog2(OFF_CYC + 1);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_CYC - 1);

    pw_state_e        state;
    logic [OFF_W-1:0] off_cnt;
    logic [3:0]       blank_left;
    logic [OFF_W:0]   low_run;

    assign mon_en   = (state == PW_RUN);
    assign blanking = (state == PW_BLANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PW_RUN;
            power_en   <= 1'b1;
            trip_pulse <= 1'b0;
            off_cnt    <= '0;
            blank_left <= '0;
        end else begin
            trip_pulse <= 1'b0;
            unique case (state)
                PW_RUN: begin
                    if (trip_req) begin
                        state      <= PW_OFF;
                        power_en   <= 1'b0;
                        trip_pulse <= 1'b1;
                        off_cnt    <= '0;
                    end
                end
                PW_OFF: begin
                    if (off_cnt == OFF_LAST) begin
                        state      <= PW_BLANK;
                        power_en   <= 1'b1;
                        blank_left <= blank_ticks;
                    end else begin
                        off_cnt <= off_cnt + 1'b1;
                    end
                end
                PW_BLANK: begin
                    if (blank_left == 4'd0) begin
                        state <= PW_RUN;
                    end else if (tick) begin
                        blank_left <= blank_left - 4'd1;
                    end
                end
                default: state <= PW_RUN;
            endcase
        end
    end

    // Independent length counter of the power-off window
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (!power_en) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    p_trip_cuts_r4: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |-> !power_en);
    p_trip_single_r4: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |=> !trip_pulse);
    p_off_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(power_en) |-> (low_run == (OFF_W+1)'(OFF_CYC)));
    p_run_powered_r6: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> power_en);

endmodule

// File: rtl/lg_event_log.sv
module lg_event_log #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trip_pulse,
    input  logic             clr,
    output logic [CNT_W-1:0] trip_count,
    output logic             sticky
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_count <= '0;
            sticky     <= 1'b0;
        end else if (clr) begin
            trip_count <= trip_pulse ? CNT_W'(1) : '0;
            sticky     <= trip_pulse;
        end else if (trip_pulse) begin
            sticky <= 1'b1;
            if (trip_count != CNT_MAX) begin
                trip_count <= trip_count + 1'b1;
            end
        end
    end

    p_count_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (trip_pulse && !clr && trip_count == CNT_MAX) |=> (trip_count == CNT_MAX));
    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!trip_pulse && !clr) |=> ($stable(trip_count) && $stable(sticky)));
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !trip_pulse) |=> (trip_count == '0 && !sticky));

endmodule

// File: rtl/latchup_guard.sv
module latchup_guard
    import lg_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter bit FAST_SIM   = 1'b0,
    parameter int ADC_W      = 12,
    parameter int TRIP_COUNT = 3,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADC_W-1:0] thresh,
    input  logic [3:0]       blank_ticks,
    input  logic             clr_trip,
    input  logic             adc_done,
    input  logic [ADC_W-1:0] adc_data,
    output logic             adc_start,
    output logic             power_en,
    output logic             trip_pulse,
    output logic [CNT_W-1:0] trip_count,
    output logic [7:0]       status
);
    localparam int SAMPLE_CYC = sample_cycles(CLK_HZ, FAST_SIM);
    localparam int OFF_CYC    = off_cycles(CLK_HZ, FAST_SIM);

    logic              tick;
    logic              mon_en;
    logic              blanking;
    logic              trip_req;
    logic              pending;
    logic              sticky;
    logic [STRK_W-1:0] streak;
    guard_status_t     stat;

    lg_tick #(.PERIOD(SAMPLE_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    lg_sampler #(.ADC_W(ADC_W), .TRIP_COUNT(TRIP_COUNT)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mon_en    (mon_en),
        .thresh    (thresh),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .adc_start (adc_start),
        .trip_req  (trip_req),
        .streak    (streak),
        .pending   (pending)
    );

    lg_power_seq #(.OFF_CYC(OFF_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .trip_req    (trip_req),
        .blank_ticks (blank_ticks),
        .power_en    (power_en),
        .trip_pulse  (trip_pulse),
        .mon_en      (mon_en),
        .blanking    (blanking)
    );

    lg_event_log #(.CNT_W(CNT_W)) u_log (
        .clk        (clk),
        .rst        (rst),
        .trip_pulse (trip_pulse),
        .clr        (clr_trip),
        .trip_count (trip_count),
        .sticky     (sticky)
    );

    always_comb begin
        stat.streak   = streak;
        stat.pending  = pending;
        stat.blanking = blanking;
        stat.power_on = power_en;
        stat.sticky   = sticky;
    end
    assign status = stat;

    p_no_start_off_r6: assert property (@(posedge clk) disable iff (rst)
        !power_en |-> !adc_start);
    p_no_start_blank_r6: assert property (@(posedge clk) disable iff (rst)
        blanking |-> !adc_start);

endmodule

// File: tb/latchup_guard_bench.sv
module latchup_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_W      = 12;
    localparam int CNT_W      = 2;
    localparam int OFF_CYC    = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ADC_W-1:0] thresh = 12'd100;
    logic [3:0]       blank_ticks = 4'd0;
    logic             clr_trip = 1'b0;
    logic             resp_done = 1'b0;
    logic             spur_done = 1'b0;
    logic [ADC_W-1:0] resp_data = '0;
    logic [ADC_W-1:0] spur_data = '0;
    logic             adc_done;
    logic [ADC_W-1:0] adc_data;
    logic             adc_start, power_en, trip_pulse;
    logic [CNT_W-1:0] trip_count;
    logic [7:0]       status;

    assign adc_done = resp_done | spur_done;
    assign adc_data = spur_done ? spur_data : resp_data;

    latchup_guard #(.CLK_HZ(100_000_000), .FAST_SIM(1'b1), .ADC_W(ADC_W),
                    .TRIP_COUNT(3), .CNT_W(CNT_W)) u_latchup_guard (
        .clk(clk), .rst(rst), .thresh(thresh), .blank_ticks(blank_ticks),
        .clr_trip(clr_trip), .adc_done(adc_done), .adc_data(adc_data),
        .adc_start(adc_start), .power_en(power_en), .trip_pulse(trip_pulse),
        .trip_count(trip_count), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int start_cnt = 0;
    int base = 0;
    int nvals = 0;
    int idx = 0;
    logic [ADC_W-1:0] fill_val = 12'd10;
    logic [ADC_W-1:0] vals [0:15];

    always @(posedge clk) if (!rst && adc_start) start_cnt <= start_cnt + 1;

    // Converter model: answers each request three cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                repeat (3) @(negedge clk);
                resp_data = (idx < nvals) ? vals[idx] : fill_val;
                idx++;
                resp_done = 1'b1;
                @(negedge clk);
                resp_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_start();
        do @(negedge clk); while (!adc_start);
        idx = 0;
        base = start_cnt;
    endtask

    task automatic wait_trip(output int samples, output bit got);
        got = 1'b0;
        samples = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (trip_pulse) begin
                got = 1'b1;
                samples = start_cnt - base;
                break;
            end
        end
    endtask

    task automatic watch_samples(input int n, output bit tripped);
        tripped = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (trip_pulse) tripped = 1'b1;
            if (start_cnt - base >= n) break;
        end
    endtask

    task automatic wait_power();
        for (int i = 0; i < 200; i++) begin
            if (power_en) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 power_en", power_en == 1'b1, power_en, 1);
        chk("R1 trip_pulse", trip_pulse == 1'b0, trip_pulse, 0);
        chk("R1 adc_start", adc_start == 1'b0, adc_start, 0);
        chk("R1 trip_count", trip_count == 0, trip_count, 0);
        chk("R1 status", status == 8'h02, status, 2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status after release", status == 8'h02, status, 2);
    endtask

    task automatic t_broken_runs();
        bit tr;
        thresh = 12'd100;
        sync_start();
        vals[0] = 150; vals[1] = 150; vals[2] = 50;
        vals[3] = 150; vals[4] = 150; vals[5] = 50;
        nvals = 6;
        watch_samples(7, tr);
        chk("R3 interrupted runs do not trip", !tr, tr, 0);
        chk("R3 power stays on", power_en == 1'b1, power_en, 1);
    endtask

    task automatic t_equal();
        bit tr;
        thresh = 12'd100;
        sync_start();
        vals[0] = 100; vals[1] = 100; vals[2] = 100; vals[3] = 100;
        nvals = 4;
        watch_samples(5, tr);
        chk("R3 equal to threshold never trips", !tr, tr, 0);
    endtask

    task automatic t_trip_basic();
        int s, n, sc;
        bit got;
        int c0;
        c0 = trip_count;
        blank_ticks = 4'd0;
        thresh = 12'd100;
        sync_start();
        vals[0] = 150; vals[1] = 150; vals[2] = 150;
        nvals = 3;
        wait_trip(s, got);
        chk("R4 trip seen", got, got, 1);
        chk("R4 trip on third exceed", s == 3, s, 3);
        chk("R4 power cut with pulse", power_en == 1'b0, power_en, 0);
        sc = start_cnt;
        n = 0;
        while (!power_en && n < 100) begin
            n++;
            @(negedge clk);
            if (n == 1) chk("R4 pulse one cycle", trip_pulse == 1'b0, trip_pulse, 0);
        end
        chk("R5 off window length", n == OFF_CYC, n, OFF_CYC);
        chk("R6 no start while off", start_cnt == sc, start_cnt - sc, 0);
        chk("R8 count incremented", trip_count == CNT_W'(c0 + 1), trip_count, c0 + 1);
        chk("R8 sticky set", status[0] == 1'b1, status[0], 1);
    endtask

    task automatic t_streak_reset();
        int s;
        bit got;
        thresh = 12'd100;
        sync_start();
        vals[0] = 150; vals[1] = 150; vals[2] = 50;
        vals[3] = 150; vals[4] = 150; vals[5] = 150;
        nvals = 6;
        wait_trip(s, got);
        chk("R3 low reading restarts streak", got && s == 6, s, 6);
        wait_power();
    endtask

    task automatic t_blank();
        int s, d;
        bit got;
        blank_ticks = 4'd2;
        sync_start();
        vals[0] = 150; vals[1] = 150; vals[2] = 150;
        nvals = 3;
        wait_trip(s, got);
        wait_power();
        chk("R6 blanking flag after return", status[2] == 1'b1, status[2], 1);
        d = 0;
        while (!adc_start && d < 400) begin @(negedge clk); d++; end
        chk("R6 two blank periods before conversion", d > 120 && d < 200, d, 129);
        blank_ticks = 4'd0;
        sync_start();
        vals[0] = 150; vals[1] = 150; vals[2] = 150;
        nvals = 3;
        wait_trip(s, got);
        wait_power();
        d = 0;
        while (!adc_start && d < 400) begin @(negedge clk); d++; end
        chk("R6 zero blank resumes within a period", d <= 70, d, 64);
    endtask

    task automatic t_threshold();
        int s;
        bit got;
        thresh = 12'd1000;
        sync_start();
        thresh = 12'd100;
        vals[0] = 150; vals[1] = 150; vals[2] = 150; vals[3] = 150;
        nvals = 4;
        wait_trip(s, got);
        chk("R7 threshold taken at conversion start", got && s == 4, s, 4);
        wait_power();
    endtask

    task automatic t_spurious();
        bit tr;
        thresh = 12'd100;
        sync_start();
        vals[0] = 20;
        nvals = 1;
        while (!resp_done) @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            spur_data = 12'd4000;
            spur_done = 1'b1;
            @(negedge clk);
            spur_done = 1'b0;
            @(negedge clk);
        end
        chk("R9 streak untouched", status[7:4] == 4'd0, status[7:4], 0);
        chk("R9 nothing pending", status[3] == 1'b0, status[3], 0);
        base = start_cnt;
        watch_samples(2, tr);
        chk("R9 no trip from unsolicited results", !tr, tr, 0);
    endtask

    task automatic t_saturate();
        int s, exp;
        bit got;
        blank_ticks = 4'd0;
        @(negedge clk); clr_trip = 1'b1;
        @(negedge clk); clr_trip = 1'b0;
        @(negedge clk);
        chk("R8 clear count", trip_count == 0, trip_count, 0);
        chk("R8 clear sticky", status[0] == 1'b0, status[0], 0);
        for (int k = 1; k <= 4; k++) begin
            sync_start();
            vals[0] = 150; vals[1] = 150; vals[2] = 150;
            nvals = 3;
            wait_trip(s, got);
            @(negedge clk);
            exp = (k > 3) ? 3 : k;
            chk("R8 saturating count", trip_count == CNT_W'(exp), trip_count, exp);
            wait_power();
        end
        chk("R8 sticky after trips", status[0] == 1'b1, status[0], 1);
        @(negedge clk); clr_trip = 1'b1;
        @(negedge clk); clr_trip = 1'b0;
        @(negedge clk);
        chk("R8 clear after saturation", trip_count == 0 && status[0] == 1'b0, trip_count, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_broken_runs();
        t_equal();
        t_trip_basic();
        t_streak_reset();
        t_blank();
        t_threshold();
        t_spurious();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule